// File: doc/BRIEF.md
# PHY Management Register Controller

This block lets host software read and write registers inside an external Ethernet PHY over the two-wire management interface, a management clock (MDC) and a bidirectional data line (MDIO). The host sees two registers: a command register that holds the PHY address, the register number and a direction flag, and a data register. Writing the command register while the block is idle launches one complete management frame. The command register also shows a busy flag that stays set until the frame has finished.

For a PHY write, software first loads the data register and then writes the command register with the write flag set. The 16-bit value is shifted out after the turnaround. For a PHY read, software writes the command register with the flag clear, polls until busy drops, and then reads the 16-bit result from the data register.

MDC is generated from the system clock by a divider set on a port. MDIO only changes while MDC falls, and incoming data is sampled on rising MDC. On a read, the line is released from the turnaround until the end of the frame. When the block is idle, MDC is held low and the line is not driven.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the command register reads 0 (busy clear, all fields 0), the data register reads 0, MDC is low and the MDIO output enable is low.
- R2: Command register layout: bits [4:0] register number, bits [9:5] PHY address, bit 10 write flag (1 = write), bit 15 busy (read-only), other bits read 0. A command write while idle starts a frame, and busy reads 1 from the next cycle on. After completion the stored fields read back unchanged.
- R3: Each frame sends, MSB first and one bit per MDC period: 32 ones, start code 01, opcode 10 for read or 01 for write, the 5-bit PHY address, then the 5-bit register number.
- R4: A write frame follows the register number with turnaround bits 10 and then the 16 data bits, taken from the data register at the moment the frame is launched. The output enable stays high for all 64 bits.
- R5: A read frame releases MDIO (output enable low) from the first turnaround bit through the last bit. The 16 bits sampled on the last 16 rising MDC edges appear, MSB first, in data register bits [15:0], with bits above 15 reading 0.
- R6: With divider setting D, each MDC half period lasts D+1 system clocks. A frame has exactly 64 rising MDC edges, and busy reads 1 for exactly 128*(D+1) cycles.
- R7: MDIO data and output enable never change in a cycle where MDC rises.
- R8: A command register write while busy is set has no effect on the frame in progress, on the stored fields or on busy. This includes a write in the cycle where the frame completes.
- R9: Data register writes are accepted while busy and do not change a write frame already in progress. If such a write falls in the cycle where a read completes, the read result is stored.
- R10: While idle, MDC stays low and the MDIO output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 1 | Write target: 0 command, 1 data |
| host_wdata | input | HOST_W | Write data |
| host_rsel | input | 1 | Read target: 0 command, 1 data |
| host_rdata | output | HOST_W | Read data of selected register |
| div_half | input | DIV_W | MDC half-period length minus one, in system clocks |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two pairs of events can fall into the same cycle. The first pair is a host register write and the completion of a frame. The bench counts 128*(D+1) clocks from the launch so that the host strobe lands exactly on the cycle in which the last falling MDC edge retires the frame. In one run it writes the command register there, and the write must be dropped, with no second frame and the old fields kept. In another run it writes the data register there during a read, and the PHY's value must win. The PHY model captures each frame bit by bit and compares it against a frame built arithmetically from the sweep indices.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DAT_W     = 16;
  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + DAT_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int TA_IDX    = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int DAT_IDX   = TA_IDX + 2;

  localparam int CB_REG_LO = 0;
  localparam int CB_PHY_LO = REG_W;
  localparam int CB_WR     = PHY_W + REG_W;
  localparam int CB_BUSY   = 15;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  typedef struct packed {
    logic             wr;
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regn;
  } mgmt_cmd_t;

  localparam int CMD_W = $bits(mgmt_cmd_t);

  function automatic logic [FRAME_LEN-1:0] build_frame(mgmt_cmd_t c, logic [DAT_W-1:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DAT_W-1:0] body;
    op   = c.wr ? 2'b01 : 2'b10;
    ta   = c.wr ? 2'b10 : 2'b00;
    body = c.wr ? d : '0;
    return {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.regn, ta, body};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             mdc,
  output logic             rise_tk,
  output logic             fall_tk
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             mdc_q, mdc_n;
  logic             tick;

  assign tick    = run && (cnt_q == div_half);
  assign rise_tk = tick && !mdc_q;
  assign fall_tk = tick && mdc_q;
  assign mdc     = mdc_q;

  always_comb begin
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (!run) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (tick) begin
      cnt_n = '0;
      mdc_n = !mdc_q;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end
endmodule

// File: rtl/mdio_frame_ser.sv
module mdio_frame_ser
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mgmt_cmd_t        cmd,
  input  logic [DAT_W-1:0] wdata,
  input  logic             rise_tk,
  input  logic             fall_tk,
  input  logic             mdio_i,
  output logic             active,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             rdone,
  output logic [DAT_W-1:0] rresult
);
  logic [FRAME_LEN-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]     idx_q, idx_n, idx_inc;
  logic                 act_q, act_n;
  logic                 oe_q, oe_n;
  logic                 rd_q, rd_n;
  logic [DAT_W-1:0]     cap_q, cap_n;
  logic                 last_bit;
  logic                 done;

  assign idx_inc  = idx_q + 1'b1;
  assign last_bit = (idx_q == CNT_W'(FRAME_LEN - 1));
  assign done     = act_q && fall_tk && last_bit;
  assign rdone    = done && rd_q;
  assign rresult  = cap_q;
  assign active   = act_q;
  assign mdio_o   = sh_q[FRAME_LEN-1];
  assign mdio_oe  = oe_q;

  always_comb begin
    sh_n  = sh_q;
    idx_n = idx_q;
    act_n = act_q;
    oe_n  = oe_q;
    rd_n  = rd_q;
    cap_n = cap_q;
    if (start && !act_q) begin
      sh_n  = build_frame(cmd, wdata);
      idx_n = '0;
      act_n = 1'b1;
      oe_n  = 1'b1;
      rd_n  = !cmd.wr;
    end else if (act_q) begin
      if (rise_tk && rd_q && (idx_q >= CNT_W'(DAT_IDX))) begin
        cap_n = {cap_q[DAT_W-2:0], mdio_i};
      end
      if (fall_tk) begin
        if (last_bit) begin
          act_n = 1'b0;
          oe_n  = 1'b0;
        end else begin
          idx_n = idx_inc;
          sh_n  = {sh_q[FRAME_LEN-2:0], 1'b0};
          oe_n  = !(rd_q && (idx_inc >= CNT_W'(TA_IDX)));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
      oe_q  <= 1'b0;
      rd_q  <= 1'b0;
      cap_q <= '0;
    end else begin
      sh_q  <= sh_n;
      idx_q <= idx_n;
      act_q <= act_n;
      oe_q  <= oe_n;
      rd_q  <= rd_n;
      cap_q <= cap_n;
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic              host_rsel,
  output logic [HOST_W-1:0] host_rdata,
  input  logic [DIV_W-1:0]  div_half,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mgmt_cmd_t        cmd_q, cmd_n;
  logic [DAT_W-1:0] data_q, data_n;
  logic             busy;
  logic             ctrl_wr, data_wr, launch;
  logic             rise_tk, fall_tk;
  logic             rdone;
  logic [DAT_W-1:0] rresult;
  logic             unused_hi;

  assign ctrl_wr   = host_wr && (host_sel == SEL_CTRL);
  assign data_wr   = host_wr && (host_sel == SEL_DATA);
  assign launch    = ctrl_wr && !busy;
  assign unused_hi = ^{1'b0, host_wdata[HOST_W-1:CB_WR+1]};

  always_comb begin
    cmd_n = cmd_q;
    if (launch) begin
      cmd_n.wr   = host_wdata[CB_WR];
      cmd_n.phy  = host_wdata[CB_PHY_LO +: PHY_W];
      cmd_n.regn = host_wdata[CB_REG_LO +: REG_W];
    end
  end

  always_comb begin
    data_n = data_q;
    if (rdone) begin
      data_n = rresult;
    end else if (data_wr) begin
      data_n = host_wdata[DAT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_n;
      data_q <= data_n;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_rsel == SEL_DATA) begin
      host_rdata[DAT_W-1:0] = data_q;
    end else begin
      host_rdata[CB_REG_LO +: REG_W] = cmd_q.regn;
      host_rdata[CB_PHY_LO +: PHY_W] = cmd_q.phy;
      host_rdata[CB_WR]              = cmd_q.wr;
      host_rdata[CB_BUSY]            = busy;
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .div_half (div_half),
    .mdc      (mdc),
    .rise_tk  (rise_tk),
    .fall_tk  (fall_tk)
  );

  mdio_frame_ser u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (launch),
    .cmd     (cmd_n),
    .wdata   (data_q),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk),
    .mdio_i  (mdio_i),
    .active  (busy),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rdone   (rdone),
    .rresult (rresult)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
  import mdio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             ctrl_wr,
  input logic [CMD_W-1:0] cmd,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe
);
  // R2
  launch_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !busy) |=> busy);

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy) |=> $stable(cmd));

  // R7
  mdio_steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R6
  mdc_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .ctrl_wr (ctrl_wr),
  .cmd     (cmd_q),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_sel, host_rsel;
  logic [31:0] host_wdata, host_rdata;
  logic [7:0]  div_half;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rsel(host_rsel), .host_rdata(host_rdata),
    .div_half(div_half), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // PHY model state
  int          bidx = 0;
  logic [63:0] line_cap, oe_cap;
  logic        phy_rd = 1'b0;
  logic [15:0] phy_resp = '0;

  // frame under test
  logic        g_rd;
  logic [4:0]  g_phy, g_reg;
  logic [15:0] g_wd;
  int          g_d;

  always @(posedge mdc) begin
    if (bidx < 64) begin
      line_cap[63-bidx] = mdio_oe ? mdio_o : mdio_i;
      oe_cap[63-bidx]   = mdio_oe;
    end
    bidx = bidx + 1;
  end

  always @(negedge mdc) begin
    if (phy_rd && bidx >= 48 && bidx <= 63) mdio_i = phy_resp[63-bidx];
    else mdio_i = 1'b1;
  end

  function automatic logic [15:0] resp_of(logic [4:0] p, logic [4:0] r);
    return {p, r, 6'h15} ^ 16'h9C3A;
  endfunction

  function automatic logic [63:0] exp_frame(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(logic sel, logic [31:0] val);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = val;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic read_reg(logic sel, output logic [31:0] v);
    host_rsel = sel;
    #0.1;
    v = host_rdata;
  endtask

  task automatic launch(logic rd, logic [4:0] p, logic [4:0] r, logic [15:0] wd, int d);
    g_rd = rd; g_phy = p; g_reg = r; g_wd = wd; g_d = d;
    div_half = 8'(d);
    phy_rd = rd; phy_resp = resp_of(p, r);
    if (!rd) host_write(1'b1, {16'h0, wd});
    bidx = 0; line_cap = '0; oe_cap = '0;
    host_write(1'b0, {21'h0, !rd, p, r});
  endtask

  task automatic finish(bit count_en, logic [15:0] exp_dreg);
    logic [31:0] v;
    int n;
    logic [63:0] ef;
    n = 0;
    read_reg(1'b0, v);
    while (v[15] && n < 100000) begin
      n++;
      @(negedge clk);
      read_reg(1'b0, v);
    end
    if (count_en) chk(n == 128*(g_d+1), "R6 busy length", 64'(n), 64'(128*(g_d+1)));
    chk(bidx == 64, "R6 rising MDC count", 64'(bidx), 64'd64);
    ef = exp_frame(g_rd, g_phy, g_reg, g_wd);
    if (g_rd) begin
      chk(line_cap[63:18] == ef[63:18], "R3 read frame header", 64'(line_cap[63:18]), 64'(ef[63:18]));
      chk(oe_cap == {46'h3FFF_FFFF_FFFF, 18'h0}, "R5 read output enable", oe_cap, {46'h3FFF_FFFF_FFFF, 18'h0});
    end else begin
      chk(line_cap[63:18] == ef[63:18], "R3 write frame header", 64'(line_cap[63:18]), 64'(ef[63:18]));
      chk(line_cap[17:0] == ef[17:0], "R4 write turnaround and data", 64'(line_cap[17:0]), 64'(ef[17:0]));
      chk(oe_cap == '1, "R4 write output enable", oe_cap, '1);
    end
    read_reg(1'b1, v);
    chk(v == {16'h0, exp_dreg}, g_rd ? "R5 read result" : "R9 data register", 64'(v), 64'(exp_dreg));
    read_reg(1'b0, v);
    chk(v == {21'h0, !g_rd, g_phy, g_reg}, "R2 command readback", 64'(v), 64'({21'h0, !g_rd, g_phy, g_reg}));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R6 watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
    host_rsel = 1'b0; div_half = 8'd1;
    repeat (3) @(negedge clk);
    // R1 reset state
    read_reg(1'b0, v); chk(v == 32'h0, "R1 command after reset", 64'(v), 64'h0);
    read_reg(1'b1, v); chk(v == 32'h0, "R1 data after reset", 64'(v), 64'h0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 MDC and enable after reset", {62'h0, mdc, mdio_oe}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle lines", {62'h0, mdc, mdio_oe}, 64'h0);

    // R3 R5: read sweep across all register numbers
    for (int r = 0; r < 32; r++) begin
      launch(1'b1, 5'd5, 5'(r), 16'h0, 1);
      finish(1'b1, resp_of(5'd5, 5'(r)));
    end
    // R3 R4: write sweep across all PHY addresses
    for (int p = 0; p < 32; p++) begin
      logic [15:0] wd;
      wd = 16'hA5C3 ^ 16'(p * 16'h0711);
      launch(1'b0, 5'(p), 5'd7, wd, 1);
      finish(1'b1, wd);
    end
    // R6: divider settings
    for (int k = 0; k < 4; k++) begin
      int d;
      d = (k == 0) ? 0 : (k == 1) ? 2 : (k == 2) ? 5 : 7;
      launch(1'b1, 5'(k + 9), 5'(3 * k), 16'h0, d);
      finish(1'b1, resp_of(5'(k + 9), 5'(3 * k)));
      launch(1'b0, 5'(k + 20), 5'(k + 1), 16'h3C00 + 16'(d), d);
      finish(1'b1, 16'h3C00 + 16'(d));
    end

    // R8: command write mid-frame is ignored
    launch(1'b1, 5'd2, 5'd4, 16'h0, 1);
    repeat (40) @(negedge clk);
    host_write(1'b0, {21'h0, 1'b1, 5'd31, 5'd31});
    finish(1'b0, resp_of(5'd2, 5'd4));

    // R8: command write in the completion cycle is ignored
    launch(1'b0, 5'd12, 5'd19, 16'h7E81, 1);
    repeat (128*2 - 2) @(negedge clk);
    host_write(1'b0, {21'h0, 1'b0, 5'd1, 5'd1});
    finish(1'b0, 16'h7E81);
    repeat (20) @(negedge clk);
    read_reg(1'b0, v);
    chk(v[15] == 1'b0 && mdc == 1'b0 && bidx == 64, "R8 no frame from completion-cycle write",
        {31'h0, v[15], 31'h0, mdc}, 64'h0);

    // R9: data write in the read completion cycle loses to the result
    launch(1'b1, 5'd6, 5'd17, 16'h0, 1);
    repeat (128*2 - 2) @(negedge clk);
    host_write(1'b1, 32'h0000BEEF);
    finish(1'b0, resp_of(5'd6, 5'd17));

    // R9: data write during a write frame leaves the frame intact
    launch(1'b0, 5'd3, 5'd8, 16'h1234, 1);
    repeat (30) @(negedge clk);
    host_write(1'b1, 32'h0000CAFE);
    finish(1'b0, 16'hCAFE);

    finished = 1;
    summary();
    $finish;
  end
endmodule